// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the programmable state of an I/O interrupt controller. That state is a small controller ID, a fixed version word, and a redirection table with one 64-bit entry per interrupt input pin. Software cannot address the table directly. It first writes an index into a select register, then reads or writes a 32-bit data window. Every 64-bit entry therefore appears as two selectable 32-bit halves.

The service logic next to this block reads decoded entry fields through a separate lookup port. It reports in-flight level interrupts by pulsing a per-pin remote-IRR set input. After any table write to a pin whose request line is high, the block emits a one-cycle "re-service" strobe for that pin, so the service logic evaluates the pin again under its new programming. A low-half write also drops the pin's remote-IRR status. Delivery of interrupts is not part of this block.

Top module: `irq_route_regs`

## Requirements
- R1: After synchronous reset every entry reads mask (bit 16 of the low half) as 1 and remote-IRR (bit 14) as 0, the ID is 0, the select register is 0, `bus_rdata` is 0 and `resvc` is 0.
- R2: Bus offset 0x00 is the select register: a write stores bits 7:0 and a read returns them zero-extended. Offset 0x10 is the data window. Any other offset reads 0 and ignores writes. Read data appears on `bus_rdata` after the second rising edge following the cycle in which `bus_rd` is sampled, and holds until the next read.
- R3: Select 0x01 reads the version word: N_PINS-1 in bits 23:16, the version code (default 0x11) in bits 7:0, and zero elsewhere. Writes to it change nothing.
- R4: A window write with select 0x00 loads the 4-bit ID from bits 27:24. Reading select 0x00 or 0x02 returns the ID in bits 27:24 and zero elsewhere. Writes with select 0x02 change nothing.
- R5: A select of 0x10 or above addresses entry (select-0x10)>>1. Select bit 0 = 1 picks bits 63:32 of the entry, and 0 picks bits 31:0. An entry index of N_PINS or more ignores writes and reads 0. Selects 0x03 to 0x0F read 0.
- R6: Remote-IRR (low-half bit 14) cannot be written from the bus. A `rirr_set` pulse sets it. A low-half write to the entry clears it, and the clear wins over a set in the same cycle. A high-half write leaves it unchanged.
- R7: The mask bit (low-half bit 16) is stored by low-half writes and reads back as written.
- R8: A table write to an in-range entry while `pin_req` for that entry is high drives `resvc` with only that pin's bit high, for exactly the one cycle after the write edge. `resvc` stays 0 in all other cases.
- R9: A bus write whose `bus_be` is not 4'hF changes no register, at any offset.
- R10: `svc_idx` presented in one cycle yields that entry's fields after the next rising edge. The fields are vector = bits 7:0, delivery mode = bits 10:8, destination mode = bit 11, polarity = bit 13, remote-IRR = bit 14, trigger = bit 15 (1 = level), mask = bit 16 and destination = bits 63:56.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_off | input | 8 | Bus offset (0x00 select, 0x10 window) |
| bus_be | input | 4 | Byte enables; only 4'hF writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_req | input | 24 | Current request bit per pin |
| rirr_set | input | 24 | Per-pin remote-IRR set pulse from the service logic |
| svc_idx | input | 5 | Entry index for the service lookup |
| svc_vector | output | 8 | Looked-up vector |
| svc_dlv | output | 3 | Looked-up delivery mode |
| svc_dmode | output | 1 | Looked-up destination mode |
| svc_pol | output | 1 | Looked-up polarity |
| svc_rirr | output | 1 | Looked-up remote-IRR status |
| svc_trig | output | 1 | Looked-up trigger mode (1 = level) |
| svc_mask | output | 1 | Looked-up mask |
| svc_dest | output | 8 | Looked-up destination |
| resvc | output | 24 | One-cycle per-pin re-service strobe |

## Verification
The embedded properties watch, on every cycle, the rules that are local in time. The re-service strobe is at most one-hot and never appears without a full-width window write one cycle earlier. A low-half write always leaves the pin's remote-IRR clear. The mask is all ones on the first cycle after reset. Narrow or misdirected writes never move the select or ID registers, and read data only moves two cycles after a read strobe. Only the bench scenarios can show that the indirect addressing lands in the right half of the right entry, that out-of-range and reserved selects read zero, and that version and ID words have the right layout. They also show that the clear-over-set priority holds against a simultaneous pulse and that the lookup port returns the programmed fields.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  // Bus offsets
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  // Select codes
  localparam int SEL_ID  = 0;
  localparam int SEL_VER = 1;
  localparam int SEL_ARB = 2;
  localparam int SEL_TBL = 16;
  // Low-half bit positions held outside the RAM
  localparam int B_RIRR = 14;
  localparam int B_MASK = 16;

  typedef enum logic [1:0] {RK_SEL, RK_WIN, RK_NONE} rd_kind_e;
endpackage

// File: rtl/irq_route_bus.sv
module irq_route_bus
  import irq_route_pkg::*;
#(
  parameter int N_PINS = 24,
  parameter int SEL_W  = 8,
  parameter int ID_W   = 4,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter int PIN_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_off,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tbl_we,
  output logic              tbl_hi,
  output logic [PIN_W-1:0]  tbl_idx,
  output logic [PIN_W-1:0]  rd_idx,
  input  logic [31:0]       mem_lo,
  input  logic [31:0]       mem_hi
);
  localparam logic [7:0] PINS_M1 = 8'(N_PINS - 1);

  logic [SEL_W-1:0] sel_q;
  logic [ID_W-1:0]  id_q;
  logic [SEL_W-1:0] rel;
  logic             tbl_ok;
  logic             full_wr;

  assign full_wr = bus_wr && (bus_be == 4'hF);
  assign rel     = sel_q - SEL_W'(SEL_TBL);
  assign tbl_ok  = (sel_q >= SEL_W'(SEL_TBL)) &&
                   (rel[SEL_W-1:1] < (SEL_W-1)'(N_PINS));
  assign tbl_idx = PIN_W'(rel[SEL_W-1:1]);
  assign tbl_hi  = sel_q[0];
  assign tbl_we  = full_wr && (bus_off == OFF_WIN) && tbl_ok;
  assign rd_idx  = tbl_ok ? tbl_idx : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (full_wr && bus_off == OFF_SEL)
        sel_q <= bus_wdata[SEL_W-1:0];
      if (full_wr && bus_off == OFF_WIN && sel_q == SEL_W'(SEL_ID))
        id_q <= bus_wdata[24 +: ID_W];
    end
  end

  // Stage 1: snapshot of the addressed state (RAM read happens in parallel)
  logic             rp1_q;
  rd_kind_e         rkind_q;
  logic [SEL_W-1:0] rsel_q;
  logic             rok_q;
  logic             rhi_q;
  logic [ID_W-1:0]  rid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rp1_q   <= 1'b0;
      rkind_q <= RK_NONE;
      rsel_q  <= '0;
      rok_q   <= 1'b0;
      rhi_q   <= 1'b0;
      rid_q   <= '0;
    end else begin
      rp1_q <= bus_rd;
      if (bus_rd) begin
        rkind_q <= (bus_off == OFF_SEL) ? RK_SEL :
                   (bus_off == OFF_WIN) ? RK_WIN : RK_NONE;
        rsel_q  <= sel_q;
        rok_q   <= tbl_ok;
        rhi_q   <= sel_q[0];
        rid_q   <= id_q;
      end
    end
  end

  // Stage 2: output word
  logic [31:0] win_word;
  logic [31:0] rd_word;

  always_comb begin
    win_word = '0;
    if (rsel_q == SEL_W'(SEL_ID) || rsel_q == SEL_W'(SEL_ARB))
      win_word[24 +: ID_W] = rid_q;
    else if (rsel_q == SEL_W'(SEL_VER))
      win_word = {8'h00, PINS_M1, 8'h00, VER_CODE};
    else if (rok_q)
      win_word = rhi_q ? mem_hi : mem_lo;
  end

  always_comb begin
    rd_word = '0;
    case (rkind_q)
      RK_SEL:  rd_word[SEL_W-1:0] = rsel_q;
      RK_WIN:  rd_word = win_word;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rp1_q) bus_rdata <= rd_word;
  end

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_be == 4'hF && bus_off == OFF_SEL) |=> $stable(sel_q)); // R9
  AST_ID_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_be == 4'hF && bus_off == OFF_WIN && sel_q == SEL_W'(SEL_ID))
    |=> $stable(id_q)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd, 2) |-> $stable(bus_rdata)); // R2
endmodule

// File: rtl/irq_route_mem.sv
module irq_route_mem
  import irq_route_pkg::*;
#(
  parameter int N_PINS = 24,
  parameter int PIN_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              we_hi,
  input  logic [PIN_W-1:0]  widx,
  input  logic [31:0]       wdata,
  input  logic [PIN_W-1:0]  rd_idx,
  input  logic [PIN_W-1:0]  svc_idx,
  input  logic [N_PINS-1:0] rirr_set,
  output logic [31:0]       bus_lo,
  output logic [31:0]       bus_hi,
  output logic [31:0]       svc_lo,
  output logic [31:0]       svc_hi
);
  logic [31:0] lo_mem [N_PINS];
  logic [31:0] hi_mem [N_PINS];
  logic [N_PINS-1:0] mask_q;
  logic [N_PINS-1:0] rirr_q;

  // Inferable RAM: one write port, registered read ports
  always_ff @(posedge clk) begin
    if (we && !we_hi) lo_mem[widx] <= wdata;
    if (we &&  we_hi) hi_mem[widx] <= wdata;
  end

  logic [31:0] bl_raw, sl_raw;
  logic        bm_q, br_q, sm_q, sr_q;

  always_ff @(posedge clk) begin
    bl_raw <= lo_mem[rd_idx];
    bus_hi <= hi_mem[rd_idx];
    sl_raw <= lo_mem[svc_idx];
    svc_hi <= hi_mem[svc_idx];
    bm_q   <= mask_q[rd_idx];
    br_q   <= rirr_q[rd_idx];
    sm_q   <= mask_q[svc_idx];
    sr_q   <= rirr_q[svc_idx];
  end

  // Per-pin status flops
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic lo_hit;
    assign lo_hit = we && !we_hi && (widx == PIN_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[i] <= 1'b1;
        rirr_q[i] <= 1'b0;
      end else begin
        if (lo_hit) mask_q[i] <= wdata[B_MASK];
        if (lo_hit)           rirr_q[i] <= 1'b0;
        else if (rirr_set[i]) rirr_q[i] <= 1'b1;
      end
    end
  end

  assign bus_lo = {bl_raw[31:17], bm_q, bl_raw[15], br_q, bl_raw[13:0]};
  assign svc_lo = {sl_raw[31:17], sm_q, sl_raw[15], sr_q, sl_raw[13:0]};

  logic unused_ram_bits;
  assign unused_ram_bits = ^{bl_raw[B_MASK], bl_raw[B_RIRR], sl_raw[B_MASK], sl_raw[B_RIRR]};

  AST_MASK_AT_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q)); // R1
  AST_RIRR_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(we && !we_hi) |-> !rirr_q[$past(widx)]); // R6
endmodule

// File: rtl/irq_route_resvc.sv
module irq_route_resvc #(
  parameter int N_PINS = 24,
  parameter int PIN_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PIN_W-1:0]  widx,
  input  logic [N_PINS-1:0] pin_req,
  output logic [N_PINS-1:0] resvc
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_rs
    always_ff @(posedge clk) begin
      if (rst) resvc[i] <= 1'b0;
      else     resvc[i] <= we && (widx == PIN_W'(i)) && pin_req[i];
    end
  end

  AST_RESVC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(resvc)); // R8
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int N_PINS = 24,
  parameter int SEL_W  = 8,
  parameter int ID_W   = 4,
  parameter logic [7:0] VER_CODE = 8'h11,
  parameter int PIN_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_off,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_req,
  input  logic [N_PINS-1:0] rirr_set,
  input  logic [PIN_W-1:0]  svc_idx,
  output logic [7:0]        svc_vector,
  output logic [2:0]        svc_dlv,
  output logic              svc_dmode,
  output logic              svc_pol,
  output logic              svc_rirr,
  output logic              svc_trig,
  output logic              svc_mask,
  output logic [7:0]        svc_dest,
  output logic [N_PINS-1:0] resvc
);
  logic             tbl_we, tbl_hi;
  logic [PIN_W-1:0] tbl_idx, rd_idx;
  logic [31:0]      mem_lo, mem_hi, s_lo, s_hi;

  irq_route_bus #(
    .N_PINS(N_PINS), .SEL_W(SEL_W), .ID_W(ID_W), .VER_CODE(VER_CODE), .PIN_W(PIN_W)
  ) u_bus (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_off(bus_off),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tbl_we(tbl_we), .tbl_hi(tbl_hi), .tbl_idx(tbl_idx), .rd_idx(rd_idx),
    .mem_lo(mem_lo), .mem_hi(mem_hi)
  );

  irq_route_mem #(.N_PINS(N_PINS), .PIN_W(PIN_W)) u_mem (
    .clk(clk), .rst(rst), .we(tbl_we), .we_hi(tbl_hi), .widx(tbl_idx),
    .wdata(bus_wdata), .rd_idx(rd_idx), .svc_idx(svc_idx), .rirr_set(rirr_set),
    .bus_lo(mem_lo), .bus_hi(mem_hi), .svc_lo(s_lo), .svc_hi(s_hi)
  );

  irq_route_resvc #(.N_PINS(N_PINS), .PIN_W(PIN_W)) u_rs (
    .clk(clk), .rst(rst), .we(tbl_we), .widx(tbl_idx), .pin_req(pin_req), .resvc(resvc)
  );

  assign svc_vector = s_lo[7:0];
  assign svc_dlv    = s_lo[10:8];
  assign svc_dmode  = s_lo[11];
  assign svc_pol    = s_lo[13];
  assign svc_rirr   = s_lo[B_RIRR];
  assign svc_trig   = s_lo[15];
  assign svc_mask   = s_lo[B_MASK];
  assign svc_dest   = s_hi[31:24];

  logic unused_svc_bits;
  assign unused_svc_bits = ^{s_lo[31:17], s_lo[12], s_hi[23:0]};

  AST_RESVC_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    (|resvc) |-> $past(bus_wr && bus_be == 4'hF && bus_off == OFF_WIN)); // R8
endmodule

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb;
  localparam int NP = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_off = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_req = '0, rirr_set = '0;
  logic [4:0]  svc_idx = '0;
  logic [7:0]  svc_vector, svc_dest;
  logic [2:0]  svc_dlv;
  logic        svc_dmode, svc_pol, svc_rirr, svc_trig, svc_mask;
  logic [NP-1:0] resvc;

  always #2 clk = ~clk;

  irq_route_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_off(bus_off),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_req(pin_req), .rirr_set(rirr_set), .svc_idx(svc_idx),
    .svc_vector(svc_vector), .svc_dlv(svc_dlv), .svc_dmode(svc_dmode),
    .svc_pol(svc_pol), .svc_rirr(svc_rirr), .svc_trig(svc_trig),
    .svc_mask(svc_mask), .svc_dest(svc_dest), .resvc(resvc)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // Reference model
  logic [31:0] lo_m [NP];
  logic [31:0] hi_m [NP];
  logic [NP-1:0] rirr_m;
  logic [3:0]  id_m;
  logic [7:0]  sel_m;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_lo(int i);
    logic [31:0] w = lo_m[i];
    w[14] = rirr_m[i];
    return w;
  endfunction

  function automatic logic [31:0] exp_win();
    int idx;
    if (sel_m == 8'd0 || sel_m == 8'd2) return {4'h0, id_m, 24'h0};
    if (sel_m == 8'd1) return {8'h00, 8'(NP - 1), 8'h00, 8'h11};
    if (sel_m < 8'h10) return 32'h0;
    idx = (int'(sel_m) - 16) >> 1;
    if (idx >= NP) return 32'h0;
    return sel_m[0] ? hi_m[idx] : exp_lo(idx);
  endfunction

  task automatic bus_write(logic [7:0] off, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_off = off; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
    if (be == 4'hF && off == 8'h00) sel_m = d[7:0];
  endtask

  task automatic bus_read(logic [7:0] off, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_off = off;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  // Window write with model update and re-service check
  task automatic win_write(logic [31:0] d, logic [3:0] be, logic [NP-1:0] rs, string req);
    int idx;
    logic [NP-1:0] exp_rs;
    bit hit;
    idx = (int'(sel_m) - 16) >> 1;
    hit = (be == 4'hF) && sel_m >= 8'h10 && idx < NP;
    exp_rs = (hit && pin_req[idx]) ? (NP'(1) << idx) : '0;
    @(negedge clk);
    bus_wr = 1'b1; bus_off = 8'h10; bus_wdata = d; bus_be = be; rirr_set = rs;
    @(negedge clk);
    bus_wr = 1'b0; rirr_set = '0;
    rirr_m = rirr_m | rs;
    if (be == 4'hF && sel_m == 8'd0) id_m = d[27:24];
    if (hit) begin
      if (sel_m[0]) hi_m[idx] = d;
      else begin lo_m[idx] = d; rirr_m[idx] = 1'b0; end
    end
    chk({req, " R8 resvc pulse"}, 32'(resvc), 32'(exp_rs));
    @(negedge clk);
    chk("R8 resvc one cycle", 32'(resvc), 32'h0);
  endtask

  task automatic win_check(string req);
    logic [31:0] d;
    logic [31:0] e;
    e = exp_win();
    bus_read(8'h10, d);
    chk(req, d, e);
  endtask

  task automatic svc_check(int i);
    logic [31:0] exp_f, act_f;
    logic [31:0] l;
    @(negedge clk); svc_idx = 5'(i);
    @(negedge clk);
    l = exp_lo(i);
    exp_f = {hi_m[i][31:24], l[16], l[15], l[14], l[13], l[11], l[10:8], l[7:0]};
    act_f = {svc_dest, svc_mask, svc_trig, svc_rirr, svc_pol, svc_dmode, svc_dlv, svc_vector};
    chk("R10 service fields", act_f, exp_f);
  endtask

  task automatic rirr_pulse(logic [NP-1:0] v);
    @(negedge clk); rirr_set = v;
    @(negedge clk); rirr_set = '0;
    rirr_m = rirr_m | v;
  endtask

  initial begin
    logic [31:0] d;
    int unsigned sd;
    sd = $urandom(32'd20517);
    for (int i = 0; i < NP; i++) begin lo_m[i] = 32'h0001_0000; hi_m[i] = '0; end
    rirr_m = '0; id_m = '0; sel_m = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdata at reset", bus_rdata, 32'h0);
    chk("R1 resvc at reset", 32'(resvc), 32'h0);
    bus_read(8'h00, d); chk("R1 select at reset", d, 32'h0);
    win_check("R1 id at reset");
    bus_write(8'h00, 32'h10, 4'hF);
    bus_read(8'h10, d); chk("R1 mask/rirr entry 0", d & 32'h0001_4000, 32'h0001_0000);
    bus_write(8'h00, 32'h3E, 4'hF);
    bus_read(8'h10, d); chk("R1 mask/rirr entry 23", d & 32'h0001_4000, 32'h0001_0000);
    svc_idx = 5'd5; @(negedge clk); @(negedge clk);
    chk("R1 svc mask at reset", {31'h0, svc_mask}, 32'h1);

    // Fill the table (pins quiet so no re-service expected)
    pin_req = '0;
    for (int s = 16; s < 16 + 2 * NP; s++) begin
      bus_write(8'h00, 32'(s), 4'hF);
      win_write($urandom, 4'hF, '0, "R5 fill");
    end

    // R2 select readback and other offsets
    bus_write(8'h00, 32'hABCD_EF21, 4'hF);
    bus_read(8'h00, d); chk("R2 select readback", d, 32'h21);
    bus_write(8'h24, 32'hFFFF_FFFF, 4'hF);
    bus_read(8'h24, d); chk("R2 other offset reads 0", d, 32'h0);
    bus_read(8'h00, d); chk("R2 other offset write ignored", d, 32'h21);
    win_check("R5 entry 8 high half");

    // R3 version, R4 id / arbitration
    bus_write(8'h00, 32'h01, 4'hF);
    win_check("R3 version word");
    win_write(32'hFFFF_FFFF, 4'hF, '0, "R3");
    win_check("R3 version write ignored");
    bus_write(8'h00, 32'h00, 4'hF);
    win_write(32'h5A00_0000, 4'hF, '0, "R4");
    win_check("R4 id readback");
    bus_write(8'h00, 32'h02, 4'hF);
    win_check("R4 arbitration mirrors id");
    win_write(32'h0300_0000, 4'hF, '0, "R4");
    win_check("R4 arbitration write ignored");
    bus_write(8'h00, 32'h07, 4'hF);
    win_check("R5 reserved select reads 0");

    // R5 out of range index
    pin_req = '1;
    bus_write(8'h00, 32'h40, 4'hF);
    win_write(32'h1234_5678, 4'hF, '0, "R5 out of range");
    win_check("R5 out of range reads 0");

    // R9 narrow writes
    bus_write(8'h00, 32'h12, 4'h7);
    bus_read(8'h00, d); chk("R9 narrow select write ignored", d, 32'h40);
    bus_write(8'h00, 32'h12, 4'hF);
    win_write(32'hDEAD_BEEF, 4'h3, '0, "R9 narrow window");
    win_check("R9 narrow window write ignored");

    // R6 remote IRR: set, high write keeps, low write clears, clear wins
    rirr_pulse(NP'(1) << 1);
    win_check("R6 rirr set by pulse (entry 1 low)");
    bus_write(8'h00, 32'h13, 4'hF);
    win_write(32'h7700_0000, 4'hF, '0, "R6 high write");
    bus_write(8'h00, 32'h12, 4'hF);
    win_check("R6 high write keeps rirr");
    win_write(32'h0000_C031, 4'hF, (NP'(1) << 1) | (NP'(1) << 2), "R6 clear wins");
    win_check("R6 low write clears rirr");
    bus_write(8'h00, 32'h14, 4'hF);
    win_check("R6 other pin set");
    svc_check(1); svc_check(2);

    // R7 mask cleared then set
    bus_write(8'h00, 32'h16, 4'hF);
    win_write(32'h0000_8042, 4'hF, '0, "R7");
    win_check("R7 mask cleared");
    win_write(32'h0001_0042, 4'hF, '0, "R7");
    win_check("R7 mask set");
    svc_check(3);

    // Constrained random mix
    for (int it = 0; it < 500; it++) begin
      int unsigned op;
      op = $urandom_range(0, 5);
      pin_req = NP'($urandom);
      case (op)
        0, 1: begin
          bus_write(8'h00, {24'($urandom), 8'($urandom_range(0, 79))}, 4'hF);
          win_write($urandom, 4'hF, '0, "R5 random write");
        end
        2: win_write($urandom, 4'($urandom_range(0, 14)), '0, "R9 random narrow");
        3: win_check("R5 random read");
        4: rirr_pulse(NP'($urandom));
        default: svc_check($urandom_range(0, NP - 1));
      endcase
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule